// File: doc/BRIEF.md
# Watchdog Timer with Prescaler

This block is a watchdog that runs from its own slow, free-running clock, separate from the CPU clock. The clock input is divided by two, then a programmable power-of-two prescaler divides it further, and the result drives an 8-bit timeout counter. When that counter wraps while the watchdog is enabled and the CPU is in a mode that allows a reset, the block sends out a single-cycle reset pulse in the watchdog clock domain. The counting restarts from zero after each pulse.

Software works from the CPU clock domain. It sets an enable level, a 3-bit ratio select and the current power mode. It also pulses a clear-watchdog strobe or a sleep strobe, and either strobe restarts a full timeout period. The level inputs pass through a two-flop synchroniser into the watchdog domain. The two strobes are merged and carried across as a toggle. The counters keep running while the CPU clock is stopped, so the watchdog still guards the system when the main oscillator is off.

Top module: `wdog_timer`

## Requirements
- R1: While `rst_n` is low, and afterwards until `cfg_enable` is set, `wdt_rst_pulse` stays 0.
- R2: With the watchdog enabled and no clear strobe, consecutive reset pulses are exactly 512·2^S cycles of `wdt_clk` apart, where S is the value of `cfg_ratio_sel` (0..7 gives prescale ratios of 1 to 128).
- R3: While the enable held in the watchdog domain is 0, no reset pulse is issued and the counting stays at zero.
- R4: A `cmd_clear` strobe clears the prescaler and the timeout counter. If clear strobes come closer together than one timeout period, no pulse occurs. After the last clear strobe, the next pulse comes 512·2^S to 512·2^S+8 `wdt_clk` cycles later.
- R5: A `cmd_sleep` strobe has the same clearing effect as `cmd_clear`.
- R6: `cfg_mode` is encoded 00 normal, 01 green, 10 idle, 11 sleep. A timeout produces a pulse in modes 00, 01 and 10, and never in mode 11.
- R7: A change of `cfg_enable` takes effect only while the mode is normal or green. In idle or sleep mode the watchdog keeps its previous enable state.
- R8: Each reset pulse lasts exactly one `wdt_clk` cycle, and the timeout counter is zero in the cycle the pulse is high.
- R9: The watchdog keeps counting and issues pulses at the R2 interval while `cpu_clk` is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU clock; may be stopped |
| wdt_clk | input | 1 | Free-running watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised separately in each domain |
| cfg_enable | input | 1 | Watchdog enable level (CPU domain) |
| cfg_ratio_sel | input | 3 | Prescale select S; ratio is 2^S (CPU domain, quasi-static) |
| cfg_mode | input | 2 | Power mode: 00 normal, 01 green, 10 idle, 11 sleep |
| cmd_clear | input | 1 | One-cycle clear-watchdog strobe (CPU domain) |
| cmd_sleep | input | 1 | One-cycle sleep-command strobe (CPU domain) |
| wdt_rst_pulse | output | 1 | One-cycle device reset request (watchdog domain) |

## Verification
Some properties are checked on every watchdog cycle. These are: the pulse is one cycle wide and the counter is zero under it; a pulse only follows a cycle with the enable set and a mode other than sleep; the enable state is frozen in idle and sleep; the counter moves by at most one step and is zero after a clear. Other behaviours need the bench scenarios. These are the exact pulse spacing for several ratio selects, the delay from a clear or sleep strobe across the clock crossing to the next pulse, the absence of pulses when disabled or in sleep mode, and the counting with the CPU clock stopped.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int unsigned WDOG_MODE_W = 2;

  typedef enum logic [WDOG_MODE_W-1:0] {
    MODE_NORMAL = 2'b00,
    MODE_GREEN  = 2'b01,
    MODE_IDLE   = 2'b10,
    MODE_SLEEP  = 2'b11
  } wdog_mode_e;
endpackage

// File: rtl/wdog_sync.sv
`timescale 1ns/1ps
// Multi-bit flop-chain synchroniser with asynchronous clear.
// With d tied high it serves as a reset-release synchroniser.
module wdog_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/wdog_pulse_xfer.sv
`timescale 1ns/1ps
// Carries a one-cycle strobe across clock domains as a level toggle.
// Strobes must be spaced by at least STAGES+2 destination cycles.
module wdog_pulse_xfer #(
  parameter int unsigned STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_strobe,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);
  logic tog_q, tog_d;
  logic tog_s;
  logic seen_q;

  always_comb begin
    tog_d = tog_q ^ src_strobe;
  end

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) tog_q <= 1'b0;
    else            tog_q <= tog_d;
  end

  wdog_sync #(.W(1), .STAGES(STAGES)) u_tog_sync (
    .clk   (dst_clk),
    .rst_n (dst_rst_n),
    .d     (tog_q),
    .q     (tog_s)
  );

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) seen_q <= 1'b0;
    else            seen_q <= tog_s;
  end

  assign dst_pulse = tog_s ^ seen_q;
endmodule

// File: rtl/wdog_prescaler.sv
`timescale 1ns/1ps
// Fixed divide-by-two stage followed by a binary prescaler whose
// tap is chosen by sel: one tick every 2 * 2^sel clock cycles.
module wdog_prescaler #(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic             half_q, half_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] mask;
  logic             pre_en;

  assign mask   = (PRE_W'(1) << sel) - PRE_W'(1);
  assign pre_en = half_q;

  always_comb begin
    half_d = half_q;
    pre_d  = pre_q;
    if (clr || !run) begin
      half_d = 1'b0;
      pre_d  = '0;
    end else begin
      half_d = ~half_q;
      if (pre_en) pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      pre_q  <= '0;
    end else begin
      half_q <= half_d;
      pre_q  <= pre_d;
    end
  end

  assign tick = run & half_q & ((pre_q & mask) == mask);
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer #(
  parameter int unsigned PRE_W       = 8,
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             cpu_clk,
  input  logic             wdt_clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic [SEL_W-1:0] cfg_ratio_sel,
  input  logic [1:0]       cfg_mode,
  input  logic             cmd_clear,
  input  logic             cmd_sleep,
  output logic             wdt_rst_pulse
);
  import wdog_pkg::*;

  localparam int unsigned        CFG_W   = 1 + SEL_W + WDOG_MODE_W;
  localparam logic [CNT_W-1:0]   CNT_MAX = {CNT_W{1'b1}};

  // Per-domain reset release
  logic cpu_rst_n, wdt_rst_n;

  wdog_sync #(.W(1), .STAGES(SYNC_STAGES)) u_cpu_rst (
    .clk (cpu_clk), .rst_n (rst_n), .d (1'b1), .q (cpu_rst_n)
  );
  wdog_sync #(.W(1), .STAGES(SYNC_STAGES)) u_wdt_rst (
    .clk (wdt_clk), .rst_n (rst_n), .d (1'b1), .q (wdt_rst_n)
  );

  // Level configuration into the watchdog domain
  logic [CFG_W-1:0] cfg_s;
  logic             en_s;
  logic [SEL_W-1:0] sel_s;
  wdog_mode_e       mode_s;

  wdog_sync #(.W(CFG_W), .STAGES(SYNC_STAGES)) u_cfg_sync (
    .clk   (wdt_clk),
    .rst_n (wdt_rst_n),
    .d     ({cfg_enable, cfg_ratio_sel, cfg_mode}),
    .q     (cfg_s)
  );

  assign en_s   = cfg_s[CFG_W-1];
  assign sel_s  = cfg_s[WDOG_MODE_W +: SEL_W];
  assign mode_s = wdog_mode_e'(cfg_s[WDOG_MODE_W-1:0]);

  // Clear and sleep strobes share one crossing
  logic clr_req, clr_pulse;
  assign clr_req = cmd_clear | cmd_sleep;

  wdog_pulse_xfer #(.STAGES(SYNC_STAGES)) u_clr_xfer (
    .src_clk    (cpu_clk),
    .src_rst_n  (cpu_rst_n),
    .src_strobe (clr_req),
    .dst_clk    (wdt_clk),
    .dst_rst_n  (wdt_rst_n),
    .dst_pulse  (clr_pulse)
  );

  // Enable state: follows software only in normal or green mode
  logic en_q, en_d, en_upd;
  logic mode_ok;

  assign en_upd  = (mode_s == MODE_NORMAL) || (mode_s == MODE_GREEN);
  assign mode_ok = (mode_s != MODE_SLEEP);

  always_comb begin
    en_d = en_q;
    if (en_upd) en_d = en_s;
  end

  // Prescaler and timeout counter
  logic             tick, expire, pre_clr;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;

  assign expire  = tick & (cnt_q == CNT_MAX) & en_q & mode_ok & ~clr_pulse;
  assign pre_clr = clr_pulse | expire;

  wdog_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk   (wdt_clk),
    .rst_n (wdt_rst_n),
    .run   (en_q),
    .clr   (pre_clr),
    .sel   (sel_s),
    .tick  (tick)
  );

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = expire;
    if (clr_pulse || expire || !en_q) cnt_d = '0;
    else if (tick)                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge wdt_clk or negedge wdt_rst_n) begin
    if (!wdt_rst_n) begin
      en_q    <= 1'b0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign wdt_rst_pulse = pulse_q;
endmodule

// File: rtl/wdog_timer_chk.sv
`timescale 1ns/1ps
module wdog_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pulse,
  input logic             en_eff,
  input logic [1:0]       mode,
  input logic             clr,
  input logic [CNT_W-1:0] cnt
);
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  p_cnt_zero_at_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (cnt == '0));

  p_no_pulse_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(en_eff));

  p_no_pulse_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> ($past(mode) != 2'b11));

  p_en_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'b10) || (mode == 2'b11)) |=> $stable(en_eff));

  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == '0));
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (wdt_clk),
  .rst_n  (wdt_rst_n),
  .pulse  (wdt_rst_pulse),
  .en_eff (en_q),
  .mode   (mode_s),
  .clr    (clr_pulse),
  .cnt    (cnt_q)
);

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;
  localparam int WDT_NS = 12;
  localparam int BASE   = 512;

  logic       cpu_gen = 1'b0;
  logic       cpu_run = 1'b1;
  logic       cpu_clk;
  logic       wdt_clk = 1'b0;
  logic       rst_n;
  logic       cfg_enable;
  logic [2:0] cfg_ratio_sel;
  logic [1:0] cfg_mode;
  logic       cmd_clear, cmd_sleep;
  logic       wdt_rst_pulse;

  always #2.5 cpu_gen = ~cpu_gen;
  always #6   wdt_clk = ~wdt_clk;
  assign cpu_clk = cpu_gen & cpu_run;

  wdog_timer dut (
    .cpu_clk(cpu_clk), .wdt_clk(wdt_clk), .rst_n(rst_n),
    .cfg_enable(cfg_enable), .cfg_ratio_sel(cfg_ratio_sel), .cfg_mode(cfg_mode),
    .cmd_clear(cmd_clear), .cmd_sleep(cmd_sleep), .wdt_rst_pulse(wdt_rst_pulse)
  );

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct { int unsigned exp; string tag; } exp_t;
  exp_t sb_q[$];

  int unsigned wcyc = 0;
  int unsigned last_cyc = 0;
  int unsigned pulse_cnt = 0;
  bit          have_last = 1'b0;
  bit          arm = 1'b0;
  bit          prev_hi = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(posedge wdt_clk) wcyc <= wcyc + 1;

  // Monitor: pulse width and scoreboard comparison of pulse spacing
  always @(negedge wdt_clk) begin
    if (wdt_rst_pulse) begin
      check(!prev_hi, "R8", "pulse wider than one cycle", 2, 1);
      if (!prev_hi) begin
        pulse_cnt = pulse_cnt + 1;
        if (arm && have_last && sb_q.size() > 0) begin
          exp_t e;
          e = sb_q.pop_front();
          check((wcyc - last_cyc) == e.exp, e.tag, "pulse interval",
                wcyc - last_cyc, e.exp);
          arm = 1'b0;
        end
        last_cyc  = wcyc;
        have_last = 1'b1;
      end
    end
    prev_hi = wdt_rst_pulse;
  end

  task automatic wait_pulse(input int tmo_ns, output bit got);
    int unsigned start;
    start = pulse_cnt;
    got = 1'b0;
    for (int t = 0; t < tmo_ns; t += WDT_NS) begin
      #(WDT_NS);
      if (pulse_cnt != start) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic set_cfg(input bit en, input int sel, input int mode);
    @(negedge cpu_gen);
    cfg_enable    = en;
    cfg_ratio_sel = 3'(sel);
    cfg_mode      = 2'(mode);
  endtask

  task automatic strobe(input bit sleep_cmd);
    @(negedge cpu_gen);
    if (sleep_cmd) cmd_sleep = 1'b1; else cmd_clear = 1'b1;
    @(negedge cpu_gen);
    cmd_sleep = 1'b0;
    cmd_clear = 1'b0;
  endtask

  // Driver: waits for a pulse boundary, pushes the expected spacing, arms
  task automatic expect_interval(input int sel, input string tag);
    int unsigned p;
    bit got;
    p = BASE << sel;
    wait_pulse(2 * p * WDT_NS + 1000, got);
    check(got, tag, "settling pulse seen", got, 1);
    wait_pulse(2 * p * WDT_NS + 1000, got);
    sb_q.push_back('{p, tag});
    arm = 1'b1;
    wait_pulse(2 * p * WDT_NS + 1000, got);
    check(got && sb_q.size() == 0, tag, "scored pulse seen", got, 1);
    arm = 1'b0;
  endtask

  task automatic expect_quiet(input int ns, input string tag);
    int unsigned c0;
    c0 = pulse_cnt;
    #(ns);
    check(pulse_cnt == c0, tag, "pulses while silenced", pulse_cnt - c0, 0);
  endtask

  task automatic clear_run(input bit sleep_cmd, input string tag);
    int unsigned c0, t0;
    bit got;
    wait_pulse(3 * BASE * WDT_NS, got);
    c0 = pulse_cnt;
    for (int k = 0; k < 6; k++) begin
      strobe(sleep_cmd);
      #3000;
    end
    check(pulse_cnt == c0, tag, "pulses during periodic clears", pulse_cnt - c0, 0);
    t0 = wcyc;
    strobe(sleep_cmd);
    wait_pulse(3 * BASE * WDT_NS, got);
    check(got && (last_cyc - t0) >= BASE && (last_cyc - t0) <= BASE + 8,
          tag, "cycles from last clear to pulse", last_cyc - t0, BASE);
  endtask

  initial begin
    #900000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_enable = 1'b0; cfg_ratio_sel = '0; cfg_mode = 2'b00;
    cmd_clear = 1'b0; cmd_sleep = 1'b0;
    #100;
    check(wdt_rst_pulse == 1'b0, "R1", "pulse during reset", wdt_rst_pulse, 0);
    rst_n = 1'b1;
    expect_quiet(8000, "R1");

    set_cfg(1, 0, 0);
    expect_interval(0, "R2");
    set_cfg(1, 1, 0);
    expect_interval(1, "R2");
    set_cfg(1, 2, 1);            // green mode, ratio 4
    expect_interval(2, "R6");
    set_cfg(1, 0, 2);            // idle mode
    expect_interval(0, "R6");

    set_cfg(0, 0, 2);            // enable dropped while idle: ignored
    expect_interval(0, "R7");

    set_cfg(0, 0, 0);            // now applied in normal mode
    #200;
    expect_quiet(3 * BASE * WDT_NS, "R3");

    set_cfg(1, 0, 0);
    clear_run(1'b0, "R4");
    clear_run(1'b1, "R5");

    set_cfg(1, 0, 3);            // sleep mode: no reset
    #200;
    expect_quiet(3 * BASE * WDT_NS, "R6");

    set_cfg(1, 0, 0);
    begin
      bit got;
      wait_pulse(3 * BASE * WDT_NS, got);
      cpu_run = 1'b0;
      wait_pulse(3 * BASE * WDT_NS, got);
      sb_q.push_back('{BASE, "R9"});
      arm = 1'b1;
      wait_pulse(3 * BASE * WDT_NS, got);
      check(got && sb_q.size() == 0, "R9", "pulse with cpu clock stopped", got, 1);
      arm = 1'b0;
      cpu_run = 1'b1;
    end

    check(sb_q.size() == 0, "R2", "scoreboard left over", sb_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule